// File: doc/BRIEF.md
# Streaming SHA-256 Padding Word Mux

This block is a purely combinational stage placed between a 32-bit streaming message input and a SHA-256 message schedule. Each cycle it takes the raw input word and produces the word the schedule has to absorb. The word is one of four kinds:

- the input word with its unused trailing bytes forced to zero;
- the input word with the 0x80 padding byte written just after the last message byte;
- an all-zero fill word;
- one 32-bit half of the 64-bit message bit length.

An external controller supplies the selectors and the running bit length. It also decides which word in the block is the last data word, which are fill words and which carry the length. This stage only forms the word.

Message bytes are packed big-endian: the earliest byte of a word sits in bits 31:24. The block raises an error flag when the selectors it receives cannot describe a legal padded stream. The controller uses that flag to mark the hash result as invalid.

Top module: `sha_pad_mux`

## Requirements
- R1: With `word_sel` = 0 (data), every byte lane whose `lane_en` bit is set passes the matching input byte unchanged. `lane_en[3]` governs bits 31:24, which hold the earliest message byte, and `lane_en[0]` governs bits 7:0.
- R2: With `word_sel` = 0, a lane whose `lane_en` bit is clear and that is not the marker lane outputs 0x00.
- R3: With `word_sel` = 0 and `mark_en` = 1, a `tail_cnt` of 1, 2 or 3 places 0x80 in bits [31-8n -: 8]. That is bits 23:16, 15:8 and 7:0 respectively, provided that lane is disabled.
- R4: With `word_sel` = 0, `mark_en` = 1 and `tail_cnt` = 0 (a full preceding word), 0x80 goes into bits 31:24. With `lane_en` = 0000 the word is therefore 0x80000000.
- R5: With `word_sel` = 1 (zero fill), `dout` is 0 whatever the values of `din`, `lane_en`, `tail_cnt` and `mark_en`.
- R6: `word_sel` = 2 outputs `bit_len[63:32]` and `word_sel` = 3 outputs `bit_len[31:0]`, so the upper half goes to the schedule first.
- R7: `err` is 1 whenever `lane_en` is not one of 0000, 1000, 1100, 1110 or 1111, meaning the enabled lanes are not contiguous from bits 31:24.
- R8: `err` is 1 whenever `mark_en` = 1 and `word_sel` is 2 or 3.
- R9: In every other case `err` is 0. When `mark_en` = 0, `tail_cnt` has no effect on `dout`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 32 | Raw big-endian message word |
| tail_cnt | input | 2 | Valid bytes in the last data word, where 0 means four |
| lane_en | input | 4 | Per-lane pass enable, bit 3 for bits 31:24 |
| mark_en | input | 1 | Insert the 0x80 padding byte |
| word_sel | input | 2 | 0 data, 1 zero fill, 2 length high, 3 length low |
| bit_len | input | 64 | Message length in bits |
| dout | output | 32 | Word for the message schedule |
| err | output | 1 | Illegal selector combination |

## Verification
Two pairs of functions can act in the same cycle, and the bench sets up both.

- **Masking and marker insertion.** Data words are applied with a partial `lane_en` and `mark_en` set. The expected word is built byte by byte from the lane rules, so a marker landing in the wrong lane, or overwriting a kept byte, shows up as a mismatch.
- **Length output and the error flag.** The bench drives a length selection together with `mark_en`, or a data word with a broken enable pattern. It then checks both that `err` rises and that `dout` still carries the value the selector asks for.

A behavioural reference compares both outputs on every cycle, under directed cases and a random sweep.

// File: rtl/sha_pad_pkg.sv
package sha_pad_pkg;

  typedef enum logic [1:0] {
    SEL_DATA   = 2'd0,
    SEL_ZERO   = 2'd1,
    SEL_LEN_HI = 2'd2,
    SEL_LEN_LO = 2'd3
  } word_sel_e;

  localparam logic [7:0] PAD_MARK = 8'h80;

endpackage

// File: rtl/sha_pad_lane_ctl.sv
module sha_pad_lane_ctl #(
  parameter int LANES = 4,
  localparam int CNT_W = $clog2(LANES)
) (
  input  logic [CNT_W-1:0] tail_cnt,
  input  logic [LANES-1:0] lane_en,
  input  logic             mark_en,
  input  logic [1:0]       word_sel,
  output logic [LANES-1:0] mark_hot,
  output logic             err
);
  import sha_pad_pkg::*;

  logic [LANES-2:0] gap;
  logic             len_sel;

  // a cleared lane above a set lane breaks the MSB-first run
  for (genvar j = 0; j < LANES - 1; j++) begin : g_gap
    assign gap[j] = lane_en[j] & ~lane_en[j+1];
  end

  // marker lane: top lane for a full previous word, else just below the tail
  for (genvar j = 0; j < LANES; j++) begin : g_mark
    if (j == LANES - 1) begin : g_top
      assign mark_hot[j] = mark_en && (tail_cnt == '0);
    end else begin : g_low
      assign mark_hot[j] = mark_en && (int'(tail_cnt) == LANES - 1 - j);
    end
  end

  assign len_sel = (word_sel == SEL_LEN_HI) || (word_sel == SEL_LEN_LO);

  always_comb begin
    err = (|gap) | (mark_en & len_sel);
  end

endmodule

// File: rtl/sha_pad_lane.sv
module sha_pad_lane (
  input  logic [7:0] byte_in,
  input  logic       keep,
  input  logic       mark,
  output logic [7:0] byte_out
);
  import sha_pad_pkg::*;

  always_comb begin
    if (keep)      byte_out = byte_in;
    else if (mark) byte_out = PAD_MARK;
    else           byte_out = 8'h00;
  end

endmodule

// File: rtl/sha_pad_mux.sv
module sha_pad_mux #(
  parameter int WORD_W = 32,
  localparam int LANES = WORD_W / 8,
  localparam int CNT_W = $clog2(LANES)
) (
  input  logic [WORD_W-1:0]   din,
  input  logic [CNT_W-1:0]    tail_cnt,
  input  logic [LANES-1:0]    lane_en,
  input  logic                mark_en,
  input  logic [1:0]          word_sel,
  input  logic [2*WORD_W-1:0] bit_len,
  output logic [WORD_W-1:0]   dout,
  output logic                err
);
  import sha_pad_pkg::*;

  logic [LANES-1:0]  mark_hot;
  logic [WORD_W-1:0] data_word;
  word_sel_e         sel;

  assign sel = word_sel_e'(word_sel);

  sha_pad_lane_ctl #(.LANES(LANES)) u_ctl (
    .tail_cnt (tail_cnt),
    .lane_en  (lane_en),
    .mark_en  (mark_en),
    .word_sel (word_sel),
    .mark_hot (mark_hot),
    .err      (err)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    sha_pad_lane u_lane (
      .byte_in  (din[8*j +: 8]),
      .keep     (lane_en[j]),
      .mark     (mark_hot[j]),
      .byte_out (data_word[8*j +: 8])
    );
  end

  always_comb begin
    unique case (sel)
      SEL_DATA:   dout = data_word;
      SEL_ZERO:   dout = '0;
      SEL_LEN_HI: dout = bit_len[2*WORD_W-1:WORD_W];
      SEL_LEN_LO: dout = bit_len[WORD_W-1:0];
      default:    dout = '0;
    endcase
  end

endmodule

// File: rtl/sha_pad_mux_chk.sv
module sha_pad_mux_chk #(
  parameter int WORD_W = 32,
  localparam int LANES = WORD_W / 8,
  localparam int CNT_W = $clog2(LANES)
) (
  input logic [WORD_W-1:0]   din,
  input logic [CNT_W-1:0]    tail_cnt,
  input logic [LANES-1:0]    lane_en,
  input logic                mark_en,
  input logic [1:0]          word_sel,
  input logic [2*WORD_W-1:0] bit_len,
  input logic [WORD_W-1:0]   dout,
  input logic                err
);
  logic [2*LANES-1:0] run;
  logic               contig;

  always_comb begin
    run    = {{LANES{1'b1}}, {LANES{1'b0}}} >> $countones(lane_en);
    contig = (lane_en == run[LANES-1:0]);

    // R5
    zero_fill_chk: assert (!(word_sel == 2'd1) || dout == '0);

    // R6
    len_hi_chk: assert (!(word_sel == 2'd2) || dout == bit_len[2*WORD_W-1:WORD_W]);

    // R6
    len_lo_chk: assert (!(word_sel == 2'd3) || dout == bit_len[WORD_W-1:0]);

    // R7
    gap_err_chk: assert (contig || err);

    // R8
    mark_len_err_chk: assert (!(mark_en && word_sel[1]) || err);

    // R1
    top_pass_chk: assert (!(word_sel == 2'd0 && lane_en[LANES-1])
                          || dout[WORD_W-1 -: 8] == din[WORD_W-1 -: 8]);
  end

endmodule

bind sha_pad_mux sha_pad_mux_chk #(.WORD_W(WORD_W)) u_chk (
  .din      (din),
  .tail_cnt (tail_cnt),
  .lane_en  (lane_en),
  .mark_en  (mark_en),
  .word_sel (word_sel),
  .bit_len  (bit_len),
  .dout     (dout),
  .err      (err)
);

// File: tb/sha_pad_mux_test.sv
module sha_pad_mux_test;

  logic        clk;
  logic [31:0] din;
  logic [1:0]  tail_cnt;
  logic [3:0]  lane_en;
  logic        mark_en;
  logic [1:0]  word_sel;
  logic [63:0] bit_len;
  logic [31:0] dout;
  logic        err;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  sha_pad_mux uut (
    .din(din), .tail_cnt(tail_cnt), .lane_en(lane_en), .mark_en(mark_en),
    .word_sel(word_sel), .bit_len(bit_len), .dout(dout), .err(err)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // behavioural reference
  function automatic logic [31:0] ref_word(logic [31:0] d, logic [1:0] t,
      logic [3:0] en, logic m, logic [1:0] s, logic [63:0] len);
    logic [31:0] w = 0;
    int mpos = (t == 0) ? 0 : int'(t);   // byte index counted from the MSB end
    if (s == 1) return 32'h0;
    if (s == 2) return len[63:32];
    if (s == 3) return len[31:0];
    for (int k = 0; k < 4; k++) begin
      int hi = 31 - 8 * k;
      if (en[3 - k])            w[hi -: 8] = d[hi -: 8];
      else if (m && k == mpos)  w[hi -: 8] = 8'h80;
      else                      w[hi -: 8] = 8'h00;
    end
    return w;
  endfunction

  function automatic logic ref_err(logic [3:0] en, logic m, logic [1:0] s);
    logic ok_run = (en == 4'b0000) || (en == 4'b1000) || (en == 4'b1100) ||
                   (en == 4'b1110) || (en == 4'b1111);
    return !ok_run || (m && s >= 2);
  endfunction

  task automatic apply(logic [31:0] d, logic [1:0] t, logic [3:0] en, logic m,
                       logic [1:0] s, logic [63:0] len, string tag);
    logic [31:0] ew;
    logic        ee;
    @(posedge clk);
    din = d; tail_cnt = t; lane_en = en; mark_en = m; word_sel = s; bit_len = len;
    ew = ref_word(d, t, en, m, s, len);
    ee = ref_err(en, m, s);
    @(negedge clk);
    checks++;
    if (dout !== ew || err !== ee) begin
      errors++;
      $display("FAIL %s dout=%h err=%b expected dout=%h err=%b", tag, dout, err, ew, ee);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] len = 64'h0123_4567_89AB_CDEF;
    din = 0; tail_cnt = 0; lane_en = 0; mark_en = 0; word_sel = 0; bit_len = 0;
    apply(0, 0, 4'b0000, 0, 0, 0, "R2 idle");
    apply(32'hDEADBEEF, 0, 4'b1111, 0, 0, len, "R1 full word");
    apply(32'hDEADBEEF, 2, 4'b1100, 0, 0, len, "R2 masked tail");
    apply(32'h61626364, 1, 4'b1000, 1, 0, len, "R3 one byte + marker");
    apply(32'h61626364, 2, 4'b1100, 1, 0, len, "R3 two bytes + marker");
    apply(32'h61626364, 3, 4'b1110, 1, 0, len, "R3 three bytes + marker");
    apply(32'hFFFFFFFF, 0, 4'b0000, 1, 0, len, "R4 marker word");
    apply(32'hFFFFFFFF, 3, 4'b1111, 1, 0, len, "R1 kept lane over marker");
    apply(32'hA5A5A5A5, 2, 4'b1111, 1, 1, len, "R5 zero fill");
    apply(32'hA5A5A5A5, 0, 4'b0000, 0, 2, len, "R6 length high");
    apply(32'hA5A5A5A5, 0, 4'b0000, 0, 3, len, "R6 length low");
    apply(32'h11223344, 0, 4'b0100, 0, 0, len, "R7 gap pattern");
    apply(32'h11223344, 0, 4'b1011, 0, 0, len, "R7 hole pattern");
    apply(32'h11223344, 0, 4'b0000, 1, 2, len, "R8 marker with length high");
    apply(32'h11223344, 0, 4'b0000, 1, 3, len, "R8 marker with length low");
    apply(32'h11223344, 1, 4'b1100, 0, 0, len, "R9 tail ignored no marker");
    apply(32'h11223344, 3, 4'b1100, 0, 0, len, "R9 tail ignored no marker");
    for (int i = 0; i < 400; i++) begin
      logic [1:0] s = 2'($urandom_range(0, 3));
      string tg = (s == 0) ? "R1/R2/R3/R4/R7/R9 sweep" :
                  (s == 1) ? "R5/R7 sweep" : "R6/R8 sweep";
      apply($urandom, 2'($urandom), 4'($urandom), 1'($urandom), s,
            {$urandom, $urandom}, tg);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule